// File: doc/BRIEF.md
# Prescaled Auto-Reload Time-Base Timer

This block is a time base. A programmable divider feeds an up-counter. The counter wraps to zero after it reaches a reload limit, and that wrap is the update event. The update event sets a sticky flag. The flag drives a level interrupt when the interrupt is enabled, and a one-cycle transfer request when the request is enabled.

Software reaches the timer through a word-addressed register port. Writes are synchronous and reads are combinational. The divider value always passes through a shadow copy that is loaded only at an update event. The reload limit passes through a shadow copy only when preload is selected. Software can also gate updates in several ways: it can suppress updates, restrict which sources raise the flag, force an update, or run a single period and then stop.

Top module: `tmr_basic`

## Requirements
- R1: After reset the control register (offset 0x00), the enable register (0x0C), the status register (0x10), the counter (0x24) and the divider (0x28) read 0. The reload register (0x2C) reads 0xFFFF. `irq` and `dma_req` are low.
- R2: While the run bit (control bit 0) is set, the counter advances once per divided tick. On the tick where it equals the effective reload limit, it returns to 0, and that wrap is an update event.
- R3: The divider register (0x28) sets a division of value+1. The count rate follows a written value only after a later update event loads the shadow copy.
- R4: With preload (control bit 7) set, a new reload value takes effect only after the next update event. With bit 7 clear, it takes effect on the next cycle.
- R5: Writing 1 to bit 0 of the event register (0x14) clears the counter and the divider phase, loads both shadows, and is an update event.
- R6: With update suppress (control bit 1) set, no update event occurs. The flag stays unchanged and the shadows keep their values, although the counter still wraps.
- R7: With source restrict (control bit 2) set, a forced update (R5) does not set the flag or raise a request, while a counter wrap still does.
- R8: With single-shot (control bit 3) set, an update event clears the run bit, which leaves the counter stopped at 0.
- R9: The update flag (status bit 0) is set by a qualifying update. Writing 0 to it clears it, and writing 1 has no effect. `irq` equals the flag ANDed with enable bit 0.
- R10: `dma_req` is high for exactly the one cycle after each qualifying update, provided enable bit 8 is set.
- R11: With control bit 11 set, reading the counter (0x24) returns the update flag in bit 31.
- R12: A counter write (0x24) while running loads the written value, and the write wins over a same-cycle tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Update interrupt level |
| dma_req | output | 1 | Update transfer request pulse |

## Verification
The counter is run with division 3 and limit 4, then with division 1 and limit 2. Its value is compared every cycle, which separates a wrong tick phase from a wrong wrap point. Mid-run writes of the divider and the reload value, made with preload on and with preload off, show whether the shadow copies are loaded at the right event. Forced updates are issued under each gating mode (suppress, restrict, single-shot). These separate an update that only clears the counter from one that also sets the flag or raises a request.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_CTRL2 = 'h04;
  localparam int OFS_IEN   = 'h0C;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_EVT   = 'h14;
  localparam int OFS_CNT   = 'h24;
  localparam int OFS_DIV   = 'h28;
  localparam int OFS_LIM   = 'h2C;

  localparam int BIT_RUN    = 0;
  localparam int BIT_NOUPD  = 1;
  localparam int BIT_ONLYOV = 2;
  localparam int BIT_SHOT   = 3;
  localparam int BIT_PRELD  = 7;
  localparam int BIT_FLGMAP = 11;
  localparam int BIT_IRQEN  = 0;
  localparam int BIT_DMAEN  = 8;
  localparam int BIT_FLAG   = 0;
  localparam int BIT_FORCE  = 0;

  typedef struct packed {
    logic flgmap;
    logic preld;
    logic shot;
    logic onlyov;
    logic noupd;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter logic [CNT_W-1:0] LIM_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_ctrl_t        ctrl,
  input  logic             dma_en,
  input  logic [PSC_W-1:0] div_val,
  input  logic [CNT_W-1:0] lim_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             force_upd,
  output logic [CNT_W-1:0] cnt,
  output logic             flag_set,
  output logic             shot_stop,
  output logic             dma_req
);
  logic [PSC_W-1:0] div_phase;
  logic [PSC_W-1:0] div_shadow;
  logic [CNT_W-1:0] lim_shadow;
  logic [CNT_W-1:0] lim_eff;
  logic             tick;
  logic             wrap;
  logic             upd_evt;

  function automatic logic f_div_done(input logic [PSC_W-1:0] ph,
                                      input logic [PSC_W-1:0] sh);
    return ph == sh;
  endfunction

  function automatic logic [PSC_W-1:0] f_div_next(input logic [PSC_W-1:0] ph,
                                                  input logic [PSC_W-1:0] sh);
    return f_div_done(ph, sh) ? '0 : ph + 1'b1;
  endfunction

  assign lim_eff   = ctrl.preld ? lim_shadow : lim_val;
  assign tick      = ctrl.run && f_div_done(div_phase, div_shadow);
  assign wrap      = tick && (cnt == lim_eff);
  assign upd_evt   = !ctrl.noupd && (wrap || force_upd);
  assign flag_set  = upd_evt && !(ctrl.onlyov && force_upd);
  assign shot_stop = upd_evt && ctrl.shot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_phase <= '0;
    end else if (force_upd) begin
      div_phase <= '0;
    end else if (ctrl.run) begin
      div_phase <= f_div_next(div_phase, div_shadow);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (force_upd) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= cnt_wdata;
    end else if (wrap) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_shadow <= '0;
      lim_shadow <= LIM_RST;
    end else if (upd_evt) begin
      div_shadow <= div_val;
      lim_shadow <= lim_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_req <= 1'b0;
    else        dma_req <= flag_set && dma_en;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !force_upd && !cnt_wr) |=> (cnt == '0)); // R2
  AST_DIV_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(div_shadow)); // R3
  AST_LIM_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(lim_shadow)); // R4
  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (cnt == '0 && div_phase == '0)); // R5
  AST_NOUPD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.noupd |-> !upd_evt); // R6
  AST_ONLYOV_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.onlyov && force_upd) |-> !flag_set); // R7
  AST_DMA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(flag_set && dma_en)); // R10
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter logic [CNT_W-1:0] LIM_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag_set,
  input  logic              shot_stop,
  output tmr_ctrl_t         ctrl,
  output logic              dma_en,
  output logic [PSC_W-1:0]  div_val,
  output logic [CNT_W-1:0]  lim_val,
  output logic              cnt_wr,
  output logic              force_upd,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic irq_en;
  logic flag;
  logic ctrl_wr, ien_wr, stat_wr, evt_wr, div_wr, lim_wr;

  function automatic logic f_hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign ctrl_wr   = wr_en && f_hit(addr, OFS_CTRL);
  assign ien_wr    = wr_en && f_hit(addr, OFS_IEN);
  assign stat_wr   = wr_en && f_hit(addr, OFS_STAT);
  assign evt_wr    = wr_en && f_hit(addr, OFS_EVT);
  assign cnt_wr    = wr_en && f_hit(addr, OFS_CNT);
  assign div_wr    = wr_en && f_hit(addr, OFS_DIV);
  assign lim_wr    = wr_en && f_hit(addr, OFS_LIM);
  assign force_upd = evt_wr && wdata[BIT_FORCE];
  assign irq       = flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl.run    <= wdata[BIT_RUN];
      ctrl.noupd  <= wdata[BIT_NOUPD];
      ctrl.onlyov <= wdata[BIT_ONLYOV];
      ctrl.shot   <= wdata[BIT_SHOT];
      ctrl.preld  <= wdata[BIT_PRELD];
      ctrl.flgmap <= wdata[BIT_FLGMAP];
    end else if (shot_stop) begin
      ctrl.run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en  <= 1'b0;
      dma_en  <= 1'b0;
      div_val <= '0;
      lim_val <= LIM_RST;
    end else begin
      if (ien_wr) begin
        irq_en <= wdata[BIT_IRQEN];
        dma_en <= wdata[BIT_DMAEN];
      end
      if (div_wr) div_val <= wdata[PSC_W-1:0];
      if (lim_wr) lim_val <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              flag <= 1'b0;
    else if (flag_set)                       flag <= 1'b1;
    else if (stat_wr && !wdata[BIT_FLAG])    flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (f_hit(addr, OFS_CTRL)) begin
      rdata[BIT_RUN]    = ctrl.run;
      rdata[BIT_NOUPD]  = ctrl.noupd;
      rdata[BIT_ONLYOV] = ctrl.onlyov;
      rdata[BIT_SHOT]   = ctrl.shot;
      rdata[BIT_PRELD]  = ctrl.preld;
      rdata[BIT_FLGMAP] = ctrl.flgmap;
    end else if (f_hit(addr, OFS_IEN)) begin
      rdata[BIT_IRQEN] = irq_en;
      rdata[BIT_DMAEN] = dma_en;
    end else if (f_hit(addr, OFS_STAT)) begin
      rdata[BIT_FLAG] = flag;
    end else if (f_hit(addr, OFS_CNT)) begin
      rdata[CNT_W-1:0]  = cnt;
      rdata[DATA_W-1]   = ctrl.flgmap && flag;
    end else if (f_hit(addr, OFS_DIV)) begin
      rdata[PSC_W-1:0] = div_val;
    end else if (f_hit(addr, OFS_LIM)) begin
      rdata[CNT_W-1:0] = lim_val;
    end
  end

  AST_FLAG_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag); // R9
  AST_ONE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata[BIT_FLAG] && !flag_set) |=> (flag == $past(flag))); // R9
  AST_SHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (shot_stop && !ctrl_wr) |=> !ctrl.run); // R8
endmodule

// File: rtl/tmr_basic.sv
module tmr_basic
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              dma_req
);
  localparam logic [CNT_W-1:0] LIM_RST = {CNT_W{1'b1}};

  tmr_ctrl_t        ctrl;
  logic             dma_en;
  logic [PSC_W-1:0] div_val;
  logic [CNT_W-1:0] lim_val;
  logic             cnt_wr;
  logic             force_upd;
  logic [CNT_W-1:0] cnt;
  logic             flag_set;
  logic             shot_stop;

  tmr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .LIM_RST(LIM_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .flag_set(flag_set), .shot_stop(shot_stop),
    .ctrl(ctrl), .dma_en(dma_en), .div_val(div_val), .lim_val(lim_val),
    .cnt_wr(cnt_wr), .force_upd(force_upd), .rdata(rdata), .irq(irq)
  );

  tmr_core #(
    .CNT_W(CNT_W), .PSC_W(PSC_W), .LIM_RST(LIM_RST)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .dma_en(dma_en),
    .div_val(div_val), .lim_val(lim_val), .cnt_wr(cnt_wr),
    .cnt_wdata(wdata[CNT_W-1:0]), .force_upd(force_upd),
    .cnt(cnt), .flag_set(flag_set), .shot_stop(shot_stop), .dma_req(dma_req)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && !dma_req)); // R1
endmodule

// File: tb/test_tmr_basic.sv
module test_tmr_basic;
  localparam logic [5:0] A_CTRL = 6'h00, A_IEN = 6'h0C, A_STAT = 6'h10,
                         A_EVT = 6'h14, A_CNT = 6'h24, A_DIV = 6'h28, A_LIM = 6'h2C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        dma_req;

  always #5 clk = ~clk;

  tmr_basic i_tmr_basic (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .dma_req(dma_req)
  );

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit finished = 0;

  bit m_run, m_noupd, m_onlyov, m_shot, m_preld, m_map, m_ien, m_den, m_flag, m_dma;
  int m_cnt, m_ph, m_div, m_divs, m_lim, m_lims;

  function automatic logic [31:0] m_read(input logic [5:0] a);
    logic [31:0] v = 0;
    case (a)
      A_CTRL: v = 32'(m_run) | (32'(m_noupd) << 1) | (32'(m_onlyov) << 2) |
                  (32'(m_shot) << 3) | (32'(m_preld) << 7) | (32'(m_map) << 11);
      A_IEN:  v = 32'(m_ien) | (32'(m_den) << 8);
      A_STAT: v = 32'(m_flag);
      A_CNT:  v = 32'(m_cnt) | ((m_map && m_flag) ? 32'h8000_0000 : 32'h0);
      A_DIV:  v = 32'(m_div);
      A_LIM:  v = 32'(m_lim);
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_model(input bit w, input logic [5:0] a, input logic [31:0] d);
    int  lim_now = m_preld ? m_lims : m_lim;
    bit  tk  = m_run && (m_ph == m_divs);
    bit  ov  = tk && (m_cnt == lim_now);
    bit  frc = w && a == A_EVT && d[0];
    bit  upd = !m_noupd && (ov || frc);
    bit  fs  = upd && !(m_onlyov && frc);
    int  n_cnt = m_cnt, n_ph = m_ph;
    if (frc) begin n_cnt = 0; n_ph = 0; end
    else begin
      if (w && a == A_CNT) n_cnt = int'(d[15:0]);
      else if (ov) n_cnt = 0;
      else if (tk) n_cnt = (m_cnt + 1) % 65536;
      if (m_run) n_ph = (m_ph == m_divs) ? 0 : m_ph + 1;
    end
    m_dma = fs && m_den;
    if (upd) begin m_divs = m_div; m_lims = m_lim; end
    if (fs) m_flag = 1;
    else if (w && a == A_STAT && !d[0]) m_flag = 0;
    if (w && a == A_CTRL) begin
      m_run = d[0]; m_noupd = d[1]; m_onlyov = d[2]; m_shot = d[3];
      m_preld = d[7]; m_map = d[11];
    end else if (upd && m_shot) m_run = 0;
    if (w && a == A_IEN) begin m_ien = d[0]; m_den = d[8]; end
    if (w && a == A_DIV) m_div = int'(d[15:0]);
    if (w && a == A_LIM) m_lim = int'(d[15:0]);
    m_cnt = n_cnt; m_ph = n_ph;
  endtask

  task automatic cyc(input bit w, input logic [5:0] a, input logic [31:0] d);
    wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    step_model(w, a, d);
    @(negedge clk);
    chk(cur_req, rdata, m_read(a));
    chk(cur_req, 32'(irq), 32'(m_flag && m_ien));
    chk(cur_req, 32'(dma_req), 32'(m_dma));
  endtask

  task automatic idle(input int n, input logic [5:0] a);
    for (int i = 0; i < n; i++) cyc(0, a, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; addr = A_CTRL; wdata = 0;
    m_run = 0; m_noupd = 0; m_onlyov = 0; m_shot = 0; m_preld = 0; m_map = 0;
    m_ien = 0; m_den = 0; m_flag = 0; m_dma = 0;
    m_cnt = 0; m_ph = 0; m_div = 0; m_divs = 0; m_lim = 65535; m_lims = 65535;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    cur_req = "R1";
    cyc(0, A_CTRL, 0); chk("R1", rdata, 0);
    cyc(0, A_LIM, 0);  chk("R1", rdata, 32'hFFFF);
    cyc(0, A_CNT, 0);  chk("R1", rdata, 0); chk("R1", 32'(irq), 0);
    cyc(0, A_STAT, 0); chk("R1", rdata, 0); chk("R1", 32'(dma_req), 0);

    // R5 forced update, R3 divider through shadow
    cur_req = "R5";
    cyc(1, A_DIV, 2); cyc(1, A_LIM, 4); cyc(1, A_IEN, 32'h101);
    cyc(1, A_EVT, 1); chk("R10", 32'(dma_req), 1);
    cyc(0, A_STAT, 0); chk("R5", rdata, 1); chk("R10", 32'(dma_req), 0);
    cur_req = "R3";
    cyc(1, A_CTRL, 1);
    idle(3, A_CNT); chk("R3", rdata, 1);
    cur_req = "R2";
    idle(30, A_CNT);
    cyc(1, A_DIV, 0);
    cur_req = "R3";
    idle(30, A_CNT);

    // R12 counter write while running
    cyc(1, A_CNT, 3); chk("R12", rdata, 3);
    cur_req = "R12";
    idle(10, A_CNT);

    // R4 preload on then off
    cur_req = "R4";
    cyc(1, A_CTRL, 32'h81); cyc(1, A_LIM, 7);
    idle(40, A_CNT);
    cyc(1, A_CTRL, 32'h01);
    cyc(1, A_EVT, 1); cyc(1, A_LIM, 2);
    idle(20, A_CNT);

    // R9 flag clear semantics and irq
    cur_req = "R9";
    cyc(1, A_CTRL, 0); cyc(1, A_STAT, 0);
    cyc(0, A_STAT, 0); chk("R9", rdata, 0); chk("R9", 32'(irq), 0);
    cyc(1, A_STAT, 1); cyc(0, A_STAT, 0); chk("R9", rdata, 0);
    cyc(1, A_EVT, 1);  cyc(0, A_STAT, 0); chk("R9", rdata, 1); chk("R9", 32'(irq), 1);
    cyc(1, A_STAT, 1); chk("R9", rdata, 1);
    cyc(1, A_STAT, 0); chk("R9", rdata, 0); chk("R9", 32'(irq), 0);

    // R11 flag mapped into counter read
    cur_req = "R11";
    cyc(1, A_EVT, 1); cyc(1, A_CTRL, 32'h800);
    cyc(0, A_CNT, 0); chk("R11", rdata, 32'h8000_0000);
    cyc(1, A_STAT, 0); cyc(0, A_CNT, 0); chk("R11", rdata, 0);

    // R7 restrict source
    cur_req = "R7";
    cyc(1, A_CTRL, 32'h04); cyc(1, A_EVT, 1); chk("R7", 32'(dma_req), 0);
    cyc(0, A_STAT, 0); chk("R7", rdata, 0);
    cyc(1, A_CTRL, 32'h05);
    idle(12, A_CNT);
    cyc(0, A_STAT, 0); chk("R7", rdata, 1);

    // R6 update suppress
    cur_req = "R6";
    cyc(1, A_CTRL, 0); cyc(1, A_STAT, 0); cyc(1, A_DIV, 5); cyc(1, A_CNT, 0);
    cyc(1, A_CTRL, 32'h03);
    idle(4, A_CNT); chk("R6", rdata, 1);
    cyc(0, A_STAT, 0); chk("R6", rdata, 0);
    cyc(1, A_EVT, 1); cyc(0, A_STAT, 0); chk("R6", rdata, 0);
    idle(10, A_CNT);

    // R8 single shot
    cur_req = "R8";
    cyc(1, A_CTRL, 0); cyc(1, A_DIV, 1); cyc(1, A_EVT, 1); cyc(1, A_STAT, 0);
    cyc(1, A_CTRL, 32'h09);
    idle(12, A_CTRL); chk("R8", rdata, 32'h08);
    cyc(0, A_CNT, 0); chk("R8", rdata, 0);
    cyc(0, A_STAT, 0); chk("R8", rdata, 1);

    // R10 request gated by its enable
    cur_req = "R10";
    cyc(1, A_IEN, 1); cyc(1, A_EVT, 1); chk("R10", 32'(dma_req), 0);
    cyc(1, A_IEN, 32'h100); cyc(1, A_EVT, 1); chk("R10", 32'(dma_req), 1);
    idle(2, A_STAT); chk("R10", 32'(dma_req), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule